// File: doc/BRIEF.md
# Misaligned Load Sequencer

This block sits between a processor load port and a data memory organized in 16-bit words, where each word address names its own pair of bytes and no two words share a byte. The processor presents byte addresses with a size of byte or word. The block converts the byte address into a word address, reads the containing word, and hands back the requested lane. Byte loads are zero-extended.

A word load at an even byte address needs one memory read. A word load at an odd byte address spans two memory words. By default the block issues two back-to-back reads and joins one byte from each read into the result. When the trap input is set, such a load performs no memory access and completes at once with a fault flag instead.

Only one load is in flight at a time. The request side uses a valid/ready handshake. The memory returns read data one cycle after a read is issued.

Top module: `ualign_load_unit`

## Requirements
- R1: The first memory read of every accepted non-faulting load uses word address = byte address shifted right by one (byte addresses 2k and 2k+1 both map to word k).
- R2: A byte load (req_size_i=0) returns bits 7:0 of the word for an even byte address and bits 15:8 for an odd one, placed in rsp_data_o[7:0] with rsp_data_o[15:8] zero.
- R3: A byte load, or a word load (req_size_i=1) at an even byte address, issues exactly one memory read, and its response is valid exactly 2 cycles after acceptance.
- R4: A word load at an odd byte address with trap_en_i=0 issues two reads on consecutive cycles, the second at the next word address, and responds exactly 3 cycles after acceptance.
- R5: For the split load of R4, rsp_data_o[7:0] is bits 15:8 of the first word read and rsp_data_o[15:8] is bits 7:0 of the second, so a load at byte address a returns byte a in the low half and byte a+1 in the high half.
- R6: When the first read of a split load is at the last word address, the second read is at word 0.
- R7: With trap_en_i=1, a word load at an odd byte address issues no memory read and responds 1 cycle after acceptance with rsp_fault_o=1 and rsp_data_o zero; rsp_fault_o is never 1 outside such a response.
- R8: req_ready_o is high only when no load is in flight: it falls on acceptance and rises again the cycle after the response.
- R9: Reset (rst_ni low) returns the block to idle: req_ready_o=1, rsp_valid_o=0, rsp_fault_o=0, mem_req_o=0, and any load in flight is dropped.
- R10: trap_en_i has no effect on byte loads or on word loads at even byte addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trap_en_i | input | 1 | 1: misaligned word loads fault instead of splitting |
| req_valid_i | input | 1 | Load request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | ADDR_W (8) | Byte address |
| req_size_i | input | 1 | 0 = byte, 1 = word |
| rsp_valid_o | output | 1 | Response valid (one-cycle pulse) |
| rsp_data_o | output | 2*LANE_W (16) | Load result |
| rsp_fault_o | output | 1 | Misaligned-trap fault, valid with rsp_valid_o |
| mem_req_o | output | 1 | Memory read strobe |
| mem_addr_o | output | ADDR_W-1 (7) | Memory word address |
| mem_rdata_i | input | 2*LANE_W (16) | Memory read data, one cycle after mem_req_o |

## Verification
Taking the acceptance edge as cycle 0, the first memory read is due in cycle 1, the second read of a split load in cycle 2, a fault response in cycle 1, an aligned or byte response in cycle 2 and a split response in cycle 3. The bench drives each request at a falling edge and then samples at every later falling edge, counting cycles from acceptance. It records each read address and the first cycle in which rsp_valid_o is high, then compares that latency, the read count and the data with the values the requirements predict. Expected data comes from a byte-value formula the bench also uses to fill its memory model, so the wrap case at the top address is predicted without reference to the design.

// File: rtl/ualign_pkg.sv
package ualign_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD1   = 3'd1,
    ST_RD2   = 3'd2,
    ST_WAIT  = 3'd3,
    ST_FAULT = 3'd4
  } seq_state_e;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } ld_size_e;
endpackage

// File: rtl/ualign_decode.sv
module ualign_decode #(
  parameter int ADDR_W = 8,
  localparam int WA_W  = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              size_i,
  input  logic              trap_en_i,
  output logic [WA_W-1:0]   word_addr_o,
  output logic              lane_o,
  output logic              split_o,
  output logic              fault_o
);
  import ualign_pkg::*;

  logic is_word;

  assign is_word     = (ld_size_e'(size_i) == SZ_WORD);
  assign word_addr_o = addr_i[ADDR_W-1:1];
  assign lane_o      = addr_i[0];
  assign split_o     = is_word && addr_i[0] && !trap_en_i;
  assign fault_o     = is_word && addr_i[0] && trap_en_i;
endmodule

// File: rtl/ualign_seq.sv
module ualign_seq #(
  parameter int ADDR_W = 8,
  localparam int WA_W  = ADDR_W - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [WA_W-1:0] word_addr_i,
  input  logic            lane_i,
  input  logic            size_i,
  input  logic            split_i,
  input  logic            fault_i,
  output logic            req_ready_o,
  output logic            mem_req_o,
  output logic [WA_W-1:0] mem_addr_o,
  output logic            cap_first_o,
  output logic            rsp_valid_o,
  output logic            rsp_fault_o,
  output logic            lane_q_o,
  output logic            size_q_o,
  output logic            split_q_o
);
  import ualign_pkg::*;

  seq_state_e      state_q, state_d;
  logic [WA_W-1:0] wa_q;
  logic            lane_q, size_q, split_q;
  logic            accept;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = fault_i ? ST_FAULT : ST_RD1;
      ST_RD1:   state_d = split_q ? ST_RD2 : ST_WAIT;
      ST_RD2:   state_d = ST_WAIT;
      ST_WAIT:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wa_q    <= '0;
      lane_q  <= 1'b0;
      size_q  <= 1'b0;
      split_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        wa_q    <= word_addr_i;
        lane_q  <= lane_i;
        size_q  <= size_i;
        split_q <= split_i;
      end
    end
  end

  // second read: next word, wraps at the top through the width
  assign mem_req_o   = (state_q == ST_RD1) || (state_q == ST_RD2);
  assign mem_addr_o  = (state_q == ST_RD2) ? wa_q + WA_W'(1) : wa_q;
  assign cap_first_o = (state_q == ST_RD2);
  assign rsp_valid_o = (state_q == ST_WAIT) || (state_q == ST_FAULT);
  assign rsp_fault_o = (state_q == ST_FAULT);
  assign lane_q_o    = lane_q;
  assign size_q_o    = size_q;
  assign split_q_o   = split_q;
endmodule

// File: rtl/ualign_merge.sv
module ualign_merge #(
  parameter int LANE_W  = 8,
  localparam int DATA_W = 2 * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_first_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_fault_i,
  input  logic              lane_i,
  input  logic              size_i,
  input  logic              split_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] rsp_data_o
);
  import ualign_pkg::*;

  logic [LANE_W-1:0] lo_lane, hi_lane, first_hi_q;
  logic [DATA_W-1:0] result;

  assign lo_lane = mem_rdata_i[LANE_W-1:0];
  assign hi_lane = mem_rdata_i[DATA_W-1:LANE_W];

  // upper byte of first word becomes the result's low byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          first_hi_q <= '0;
    else if (cap_first_i) first_hi_q <= hi_lane;
  end

  always_comb begin
    if (split_i)                              result = {lo_lane, first_hi_q};
    else if (ld_size_e'(size_i) == SZ_WORD)   result = mem_rdata_i;
    else if (lane_i)                          result = {{LANE_W{1'b0}}, hi_lane};
    else                                      result = {{LANE_W{1'b0}}, lo_lane};
  end

  assign rsp_data_o = (rsp_valid_i && !rsp_fault_i) ? result : '0;
endmodule

// File: rtl/ualign_load_unit.sv
module ualign_load_unit #(
  parameter int ADDR_W  = 8,
  parameter int LANE_W  = 8,
  localparam int WA_W   = ADDR_W - 1,
  localparam int DATA_W = 2 * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_en_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_size_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_fault_o,
  output logic              mem_req_o,
  output logic [WA_W-1:0]   mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [WA_W-1:0] dec_wa;
  logic            dec_lane, dec_split, dec_fault;
  logic            cap_first, lane_q, size_q, split_q;

  ualign_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i      (req_addr_i),
    .size_i      (req_size_i),
    .trap_en_i   (trap_en_i),
    .word_addr_o (dec_wa),
    .lane_o      (dec_lane),
    .split_o     (dec_split),
    .fault_o     (dec_fault)
  );

  ualign_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .word_addr_i (dec_wa),
    .lane_i      (dec_lane),
    .size_i      (req_size_i),
    .split_i     (dec_split),
    .fault_i     (dec_fault),
    .req_ready_o (req_ready_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .cap_first_o (cap_first),
    .rsp_valid_o (rsp_valid_o),
    .rsp_fault_o (rsp_fault_o),
    .lane_q_o    (lane_q),
    .size_q_o    (size_q),
    .split_q_o   (split_q)
  );

  ualign_merge #(.LANE_W(LANE_W)) u_merge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_first_i (cap_first),
    .rsp_valid_i (rsp_valid_o),
    .rsp_fault_i (rsp_fault_o),
    .lane_i      (lane_q),
    .size_i      (size_q),
    .split_i     (split_q),
    .mem_rdata_i (mem_rdata_i),
    .rsp_data_o  (rsp_data_o)
  );
endmodule

// File: rtl/ualign_load_chk.sv
module ualign_load_chk #(
  parameter int ADDR_W  = 8,
  parameter int LANE_W  = 8,
  localparam int WA_W   = ADDR_W - 1,
  localparam int DATA_W = 2 * LANE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trap_en_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_size_i,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              rsp_fault_o,
  input logic              mem_req_o,
  input logic [WA_W-1:0]   mem_addr_o,
  input logic [DATA_W-1:0] mem_rdata_i
);
  logic acc, acc_trap;
  assign acc      = req_valid_i && req_ready_o;
  assign acc_trap = acc && trap_en_i && req_size_i && req_addr_i[0];

  // R1
  first_read_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !acc_trap) |=> (mem_req_o && mem_addr_o == $past(req_addr_i[ADDR_W-1:1])));

  // R4
  second_read_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> (mem_addr_o == $past(mem_addr_o) + WA_W'(1)));

  // R7
  trap_no_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_trap |=> (rsp_valid_o && rsp_fault_o && !mem_req_o && rsp_data_o == '0));

  // R7
  fault_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_valid_o);

  // R8
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || mem_req_o) |-> !req_ready_o);

  // R8
  ready_after_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> req_ready_o);

  // R9
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (req_ready_o && !rsp_valid_o && !rsp_fault_o && !mem_req_o));
endmodule

bind ualign_load_unit ualign_load_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trap_en_i   (trap_en_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_addr_i  (req_addr_i),
  .req_size_i  (req_size_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_data_o  (rsp_data_o),
  .rsp_fault_o (rsp_fault_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rdata_i (mem_rdata_i)
);

// File: tb/tb_ualign_load_unit.sv
`timescale 1ns/1ps
module tb_ualign_load_unit;
  localparam int ADDR_W = 8;
  localparam int LANE_W = 8;
  localparam int WA_W   = ADDR_W - 1;
  localparam int DATA_W = 2 * LANE_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              trap_en = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_size = 1'b0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_fault;
  logic              mem_req;
  logic [WA_W-1:0]   mem_addr;
  logic [DATA_W-1:0] mem_rdata = '0;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  ualign_load_unit #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .trap_en_i(trap_en),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_size_i(req_size),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_fault_o(rsp_fault),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [LANE_W-1:0] bval(input logic [ADDR_W-1:0] b);
    return LANE_W'(int'(b) * 37 + 11);
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk)
    if (mem_req)
      mem_rdata <= {bval({mem_addr, 1'b1}), bval({mem_addr, 1'b0})};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // issue one load; report latency, data, fault, read count and addresses
  task automatic do_load(input logic [ADDR_W-1:0] a, input logic sz, input logic trap,
                         output int lat, output int dat, output int flt,
                         output int nrd, output int rd0, output int rd1,
                         output int busy_ready);
    lat = 0; dat = 0; flt = 0; nrd = 0; rd0 = -1; rd1 = -1; busy_ready = 0;
    @(negedge clk);
    req_addr = a; req_size = sz; trap_en = trap; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k < 10; k++) begin
      if (mem_req) begin
        if (nrd == 0) rd0 = int'(mem_addr); else rd1 = int'(mem_addr);
        nrd++;
      end
      if (req_ready) busy_ready++;
      if (rsp_valid) begin
        lat = k; dat = int'(rsp_data); flt = int'(rsp_fault);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    if (!req_ready) busy_ready += 100;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready", int'(req_ready), 1);
    check(rsp_valid == 1'b0 && rsp_fault == 1'b0, "R9 rsp", int'({rsp_valid, rsp_fault}), 0);
    check(mem_req == 1'b0, "R9 mem_req", int'(mem_req), 0);
  endtask

  task automatic t_byte(input logic [ADDR_W-1:0] a, input logic trap);
    int lat, dat, flt, nrd, r0, r1, br;
    do_load(a, 1'b0, trap, lat, dat, flt, nrd, r0, r1, br);
    check(r0 == int'(a >> 1), "R1 byte word addr", r0, int'(a >> 1));
    check(dat == int'(bval(a)), "R2 byte lane", dat, int'(bval(a)));
    check(lat == 2 && nrd == 1, "R3 byte latency/reads", lat*16+nrd, 2*16+1);
    check(flt == 0, "R10 byte no fault", flt, 0);
    check(br == 0, "R8 ready", br, 0);
  endtask

  task automatic t_word_even(input logic [ADDR_W-1:0] a, input logic trap);
    int lat, dat, flt, nrd, r0, r1, br, exp;
    exp = int'({bval(a + 1'b1), bval(a)});
    do_load(a, 1'b1, trap, lat, dat, flt, nrd, r0, r1, br);
    check(r0 == int'(a >> 1), "R1 word addr", r0, int'(a >> 1));
    check(dat == exp, "R3 aligned data", dat, exp);
    check(lat == 2 && nrd == 1, "R3 aligned latency/reads", lat*16+nrd, 2*16+1);
    check(flt == 0, "R10 aligned no fault", flt, 0);
    check(br == 0, "R8 ready", br, 0);
  endtask

  task automatic t_word_odd(input logic [ADDR_W-1:0] a);
    int lat, dat, flt, nrd, r0, r1, br, exp, w1;
    exp = int'({bval(a + 1'b1), bval(a)});
    w1  = int'(WA_W'((a >> 1) + 1));
    do_load(a, 1'b1, 1'b0, lat, dat, flt, nrd, r0, r1, br);
    check(lat == 3 && nrd == 2, "R4 split latency/reads", lat*16+nrd, 3*16+2);
    check(r0 == int'(a >> 1) && r1 == w1, "R4 R6 split addrs", r0*256+r1, int'(a >> 1)*256+w1);
    check(dat == exp, "R5 merged data", dat, exp);
    check(flt == 0, "R5 no fault", flt, 0);
    check(br == 0, "R8 ready", br, 0);
  endtask

  task automatic t_trap(input logic [ADDR_W-1:0] a);
    int lat, dat, flt, nrd, r0, r1, br;
    do_load(a, 1'b1, 1'b1, lat, dat, flt, nrd, r0, r1, br);
    check(lat == 1 && flt == 1, "R7 fault latency", lat*16+flt, 1*16+1);
    check(nrd == 0, "R7 no memory read", nrd, 0);
    check(dat == 0, "R7 data zero", dat, 0);
    check(br == 0, "R8 ready", br, 0);
  endtask

  task automatic t_reset_midflight();
    @(negedge clk);
    req_addr = 8'h21; req_size = 1'b1; trap_en = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rst_ni = 1'b0;
    #1;
    check(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req == 1'b0, "R9 midflight",
          int'({req_ready, rsp_valid, mem_req}), 3'b100);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 dropped load", int'(rsp_valid), 0);
    t_word_odd(8'h21);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte(8'h10, 1'b0);
    t_byte(8'h11, 1'b0);
    t_byte(8'hFF, 1'b1);
    t_word_even(8'h40, 1'b0);
    t_word_even(8'h7E, 1'b1);
    t_word_odd(8'h01);
    t_word_odd(8'h35);
    t_word_odd(8'hFF);
    t_trap(8'h03);
    t_trap(8'hFF);
    t_word_odd(8'h03);
    t_reset_midflight();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule